// File: doc/BRIEF.md
# Fixed-Point Harmonic Oscillator RK4 Stepper

This block advances the undamped oscillator dx/dt = y, dy/dt = −x by one fourth-order Runge–Kutta step each time it is strobed. The RK4 stages for this system fold into one closed update per state variable. That update uses three constants that depend only on the step size h: a cross gain a1 = h − h³/6 applied to y in the x update, the opposite gain a2 = h³/6 − h applied to x in the y update, and a shared self gain a3 = h⁴/24 − h²/2. The x and y updates are two separate multiply-add lanes. They read the same coefficient registers and finish in the same clock, so the serial chain of eight operations shrinks to one register stage.

All values are signed 32-bit fixed point with 14 fractional bits, so 1.0 is 16384. The host computes the coefficients from h and writes them through a small select/data port. It loads a starting state such as x = 1, y = 0, then raises the step strobe once per step, or holds it high to step on every clock. Each new state appears on the outputs together with a one-cycle valid pulse. A mode input lets the y lane use the negation of a1, so the second cross gain does not need its own write.

Top module: `osc_rk4_stepper`

## Requirements
- R1: While reset is low and after it is released, x_out and y_out read 0, out_valid is low and all three coefficient registers hold 0.
- R2: When init_we is high at a clock edge, x_out and y_out show init_x and init_y after that edge and out_valid stays low. If neither init_we nor step is high, the state holds its value.
- R3: A step computes x' = x + P(y,a1) + P(x,a3) and y' = y + P(x,a2) + P(y,a3). P(u,v) is the full 64-bit product u·v plus 8192, arithmetically shifted right by 14 and saturated to the signed 32-bit range.
- R4: Both new states come from the state before the edge and are written at the same edge. A strobe held high for n cycles advances the state n times.
- R5: out_valid is high for exactly the cycle that follows each accepted step, and low in every other cycle.
- R6: With coef_we high, coef_sel 0 writes a1, 1 writes a2, 2 writes a3, and 3 changes nothing. A write is seen by steps from the next cycle on. A step in the same cycle as a write uses the old value.
- R7: With a2_from_a1 high during a step, the y lane uses −a1 instead of the stored a2, and −(−2^31) becomes 2^31−1. The result is bit-identical to loading that value as a2 with the mode low.
- R8: If init_we and step are high in the same cycle, the state takes the init values and out_valid stays low.
- R9: Each three-term sum saturates to 2^31−1 or −2^31 instead of wrapping.
- R10: With coefficients rounded from h = 0.001 and the start state (1, 0), 6300 consecutive steps keep √(x² + y²) within 0.01 of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 2 | Coefficient select: 0 a1, 1 a2, 2 a3, 3 none |
| coef_data | input | 32 | Coefficient value, Q17.14 |
| a2_from_a1 | input | 1 | Use −a1 as the y-lane cross gain |
| init_we | input | 1 | Load initial state strobe |
| init_x | input | 32 | Initial x, Q17.14 |
| init_y | input | 32 | Initial y, Q17.14 |
| step | input | 1 | Advance one RK4 step |
| x_out | output | 32 | Current x, Q17.14 |
| y_out | output | 32 | Current y, Q17.14 |
| out_valid | output | 1 | Pulses one cycle after each step |

## Verification
The hardest condition to reach from the ports is a product that leaves the 32-bit range before the sum is formed. Real step sizes give tiny gains, so this never happens on its own. The bench reaches it with a vector that pairs a full-scale state with a full-scale gain and a small opposite-sign term. A product that wrapped instead of clamping would then give a visibly different sum. Other hard cases are a coefficient write in the same cycle as a step, and a −2^31 value for a1 under the negation mode. Both are driven directly.

// File: rtl/osc_rk4_pkg.sv
package osc_rk4_pkg;
    localparam int unsigned OSC_DATA_W = 32;
    localparam int unsigned OSC_FRAC_W = 14;
    localparam int unsigned OSC_LANES  = 2;

    typedef enum logic [1:0] {
        SEL_GAIN_XY = 2'd0,
        SEL_GAIN_YX = 2'd1,
        SEL_GAIN_SS = 2'd2,
        SEL_NONE    = 2'd3
    } coef_sel_e;
endpackage

// File: rtl/osc_fx_mul.sv
// Fixed-point multiply: full product, round half up, rescale, saturate.
module osc_fx_mul #(
    parameter int unsigned W = osc_rk4_pkg::OSC_DATA_W,
    parameter int unsigned F = osc_rk4_pkg::OSC_FRAC_W
) (
    input  logic signed [W-1:0] op_a,
    input  logic signed [W-1:0] op_b,
    output logic signed [W-1:0] prod
);
    localparam int unsigned PW = 2 * W;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (F - 1);
    localparam logic signed [W-1:0]  MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0]  MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [PW-1:0] full_p;
    logic signed [PW-1:0] scaled;
    logic                 fits;

    always_comb begin
        full_p = PW'(op_a) * PW'(op_b);
        scaled = (full_p + HALF) >>> F;
        fits   = (&scaled[PW-1:W-1]) | ~(|scaled[PW-1:W-1]);
        if (fits) begin
            prod = scaled[W-1:0];
        end else if (scaled[PW-1]) begin
            prod = MINV;
        end else begin
            prod = MAXV;
        end
    end
endmodule

// File: rtl/osc_lane.sv
// One state lane: own value plus cross and self products, saturating sum.
module osc_lane #(
    parameter int unsigned W = osc_rk4_pkg::OSC_DATA_W,
    parameter int unsigned F = osc_rk4_pkg::OSC_FRAC_W
) (
    input  logic signed [W-1:0] own_v,
    input  logic signed [W-1:0] other_v,
    input  logic signed [W-1:0] gain_cross,
    input  logic signed [W-1:0] gain_self,
    output logic signed [W-1:0] next_v
);
    localparam int unsigned SW = W + 2;
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [W-1:0]  p_cross;
    logic signed [W-1:0]  p_self;
    logic signed [SW-1:0] acc;
    logic                 fits;

    osc_fx_mul #(.W(W), .F(F)) u_mul_cross (
        .op_a (other_v),
        .op_b (gain_cross),
        .prod (p_cross)
    );

    osc_fx_mul #(.W(W), .F(F)) u_mul_self (
        .op_a (own_v),
        .op_b (gain_self),
        .prod (p_self)
    );

    always_comb begin
        acc  = SW'(own_v) + SW'(p_cross) + SW'(p_self);
        fits = (&acc[SW-1:W-1]) | ~(|acc[SW-1:W-1]);
        if (fits) begin
            next_v = acc[W-1:0];
        end else if (acc[SW-1]) begin
            next_v = MINV;
        end else begin
            next_v = MAXV;
        end
    end
endmodule

// File: rtl/osc_coef_bank.sv
// Three shared gain registers with optional derived y-lane cross gain.
module osc_coef_bank #(
    parameter int unsigned W = osc_rk4_pkg::OSC_DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic signed [W-1:0] wr_data,
    input  logic                derive_yx,
    output logic signed [W-1:0] gain_xy,
    output logic signed [W-1:0] gain_yx,
    output logic signed [W-1:0] gain_ss
);
    import osc_rk4_pkg::*;

    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic signed [W-1:0] g_xy;
        logic signed [W-1:0] g_yx;
        logic signed [W-1:0] g_ss;
    } gains_t;

    gains_t              gains_d, gains_q;
    logic signed [W-1:0] neg_xy;

    always_comb begin
        gains_d = gains_q;
        if (wr_en) begin
            unique case (coef_sel_e'(wr_sel))
                SEL_GAIN_XY: gains_d.g_xy = wr_data;
                SEL_GAIN_YX: gains_d.g_yx = wr_data;
                SEL_GAIN_SS: gains_d.g_ss = wr_data;
                default:     gains_d      = gains_q;
            endcase
        end
        neg_xy  = (gains_q.g_xy == MINV) ? MAXV : -gains_q.g_xy;
        gain_xy = gains_q.g_xy;
        gain_yx = derive_yx ? neg_xy : gains_q.g_yx;
        gain_ss = gains_q.g_ss;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gains_q <= '0;
        end else begin
            gains_q <= gains_d;
        end
    end
endmodule

// File: rtl/osc_rk4_stepper.sv
// Oscillator RK4 stepper: two parallel lanes sharing one gain bank.
module osc_rk4_stepper #(
    parameter int unsigned DATA_W = osc_rk4_pkg::OSC_DATA_W,
    parameter int unsigned FRAC_W = osc_rk4_pkg::OSC_FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     coef_we,
    input  logic [1:0]               coef_sel,
    input  logic signed [DATA_W-1:0] coef_data,
    input  logic                     a2_from_a1,
    input  logic                     init_we,
    input  logic signed [DATA_W-1:0] init_x,
    input  logic signed [DATA_W-1:0] init_y,
    input  logic                     step,
    output logic signed [DATA_W-1:0] x_out,
    output logic signed [DATA_W-1:0] y_out,
    output logic                     out_valid
);
    import osc_rk4_pkg::*;

    localparam int unsigned NL = OSC_LANES;

    typedef struct packed {
        logic signed [DATA_W-1:0] x;
        logic signed [DATA_W-1:0] y;
        logic                     vld;
    } state_t;

    state_t st_d, st_q;

    logic signed [DATA_W-1:0] g_xy, g_yx, g_ss;
    logic signed [DATA_W-1:0] lane_own   [NL];
    logic signed [DATA_W-1:0] lane_other [NL];
    logic signed [DATA_W-1:0] lane_gain  [NL];
    logic signed [DATA_W-1:0] lane_next  [NL];

    osc_coef_bank #(.W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (coef_we),
        .wr_sel    (coef_sel),
        .wr_data   (coef_data),
        .derive_yx (a2_from_a1),
        .gain_xy   (g_xy),
        .gain_yx   (g_yx),
        .gain_ss   (g_ss)
    );

    for (genvar g = 0; g < NL; g++) begin : g_lane
        if (g == 0) begin : g_x
            assign lane_own[g]   = st_q.x;
            assign lane_other[g] = st_q.y;
            assign lane_gain[g]  = g_xy;
        end else begin : g_y
            assign lane_own[g]   = st_q.y;
            assign lane_other[g] = st_q.x;
            assign lane_gain[g]  = g_yx;
        end

        osc_lane #(.W(DATA_W), .F(FRAC_W)) u_lane (
            .own_v      (lane_own[g]),
            .other_v    (lane_other[g]),
            .gain_cross (lane_gain[g]),
            .gain_self  (g_ss),
            .next_v     (lane_next[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (init_we) begin
            st_d.x = init_x;
            st_d.y = init_y;
        end else if (step) begin
            st_d.x   = lane_next[0];
            st_d.y   = lane_next[1];
            st_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign x_out     = st_q.x;
    assign y_out     = st_q.y;
    assign out_valid = st_q.vld;
endmodule

// File: rtl/osc_rk4_checker.sv
module osc_rk4_checker #(
    parameter int unsigned W = osc_rk4_pkg::OSC_DATA_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                init_we,
    input logic                step,
    input logic signed [W-1:0] init_x,
    input logic signed [W-1:0] init_y,
    input logic signed [W-1:0] x_out,
    input logic signed [W-1:0] y_out,
    input logic                out_valid
);
    assert_init_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_we |=> (x_out == $past(init_x)) && (y_out == $past(init_y)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_we && !step) |=> $stable(x_out) && $stable(y_out));

    assert_valid_after_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init_we) |=> out_valid);

    assert_valid_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !out_valid);

    assert_init_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_we && step) |=> !out_valid);
endmodule

bind osc_rk4_stepper osc_rk4_checker u_chk (.*);

// File: tb/sim_osc_rk4_stepper.sv
`timescale 1ns/1ps
module sim_osc_rk4_stepper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        coef_we = 1'b0;
    logic [1:0]  coef_sel = 2'd0;
    logic signed [31:0] coef_data = '0;
    logic        a2_from_a1 = 1'b0;
    logic        init_we = 1'b0;
    logic signed [31:0] init_x = '0;
    logic signed [31:0] init_y = '0;
    logic        step = 1'b0;
    logic signed [31:0] x_out, y_out;
    logic        out_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    osc_rk4_stepper u0 (.*);

    typedef struct packed {
        int x0; int y0; int a1; int a2; int a3; int ex; int ey;
    } vec_t;

    // R3 R4 R9: hand-derived single-step results
    localparam vec_t VECS [7] = '{
        '{16384, 0, 16384, -16384, 0, 16384, -16384},
        '{8192, 4096, 8192, -8192, -4096, 8192, -1024},
        '{1, 1, 8192, 8191, -8192, 2, 1},
        '{-3, 5, -8193, 24576, 16384, -9, 6},
        '{32'h40000000, 32'h40000000, 16384, 16384, 0, 32'h7FFFFFFF, 32'h7FFFFFFF},
        '{32'hC0000000, 32'hC0000000, 16384, 16384, 16384, 32'h80000000, 32'h80000000},
        '{-16384, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 0, 2147467263, 32'h7FFFFFFF}
    };

    function automatic int sat32(longint v);
        if (v > 64'sd2147483647) return 32'h7FFFFFFF;
        if (v < -64'sd2147483648) return 32'h80000000;
        return int'(v);
    endfunction

    function automatic int pmul(int a, int b);
        longint p;
        p = longint'(a) * longint'(b);
        p = (p + 64'sd8192) >>> 14;
        return sat32(p);
    endfunction

    function automatic void model(input int x, input int y, input int a1, input int a2,
                                  input int a3, output int nx, output int ny);
        nx = sat32(longint'(x) + longint'(pmul(y, a1)) + longint'(pmul(x, a3)));
        ny = sat32(longint'(y) + longint'(pmul(x, a2)) + longint'(pmul(y, a3)));
    endfunction

    function automatic int to_fx(real v);
        return $rtoi(v * 16384.0 + ((v >= 0.0) ? 0.5 : -0.5));
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_coef(logic [1:0] sel, int val);
        coef_we = 1'b1; coef_sel = sel; coef_data = val;
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic load_state(int x, int y);
        init_we = 1'b1; init_x = x; init_y = y;
        @(negedge clk);
        init_we = 1'b0;
    endtask

    task automatic pulse_step();
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic set_gains(int a1, int a2, int a3);
        wr_coef(2'd0, a1);
        wr_coef(2'd1, a2);
        wr_coef(2'd2, a3);
    endtask

    initial begin
        int ex, ey, ex2, ey2, k1, k2, k3;
        int mx, my, mism;
        real ax, ay, amp;
        repeat (3) @(negedge clk);
        check("R1 x", x_out, 0);
        check("R1 y", y_out, 0);
        check("R1 valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: coefficients are zero after reset, so a step leaves the state unchanged
        load_state(5000, -7000);
        pulse_step();
        check("R1 gains zero x", x_out, 5000);
        check("R1 gains zero y", y_out, -7000);

        foreach (VECS[i]) begin
            load_state(VECS[i].x0, VECS[i].y0);
            set_gains(VECS[i].a1, VECS[i].a2, VECS[i].a3);
            pulse_step();
            check((i >= 4) ? "R9 x" : "R3 x", x_out, VECS[i].ex);
            check((i >= 4) ? "R9 y" : "R3 y", y_out, VECS[i].ey);
            check("R5 valid after step", int'(out_valid), 1);
            @(negedge clk);
            check("R5 valid drops", int'(out_valid), 0);
        end

        // R2: init load, no valid, then hold
        load_state(1234, -567);
        check("R2 x", x_out, 1234);
        check("R2 y", y_out, -567);
        check("R2 no valid", int'(out_valid), 0);
        repeat (3) @(negedge clk);
        check("R2 hold x", x_out, 1234);

        // R8: init and step together
        set_gains(1636, -1636, -82);
        init_we = 1'b1; init_x = 777; init_y = 888; step = 1'b1;
        @(negedge clk);
        init_we = 1'b0; step = 1'b0;
        check("R8 x", x_out, 777);
        check("R8 y", y_out, 888);
        check("R8 no valid", int'(out_valid), 0);

        // R4: back-to-back steps, each from the prior state
        load_state(16384, 0);
        step = 1'b1;
        @(negedge clk);
        model(16384, 0, 1636, -1636, -82, ex, ey);
        check("R4 step1 x", x_out, ex);
        check("R4 step1 y", y_out, ey);
        @(negedge clk);
        step = 1'b0;
        model(ex, ey, 1636, -1636, -82, ex2, ey2);
        check("R4 step2 x", x_out, ex2);
        check("R4 step2 y", y_out, ey2);
        check("R5 valid held", int'(out_valid), 1);

        // R6: write in same cycle as a step uses the old gain
        set_gains(16384, -16384, 0);
        load_state(16384, 0);
        coef_we = 1'b1; coef_sel = 2'd1; coef_data = 0; step = 1'b1;
        @(negedge clk);
        coef_we = 1'b0; step = 1'b0;
        check("R6 old gain y", y_out, -16384);
        pulse_step();
        check("R6 new gain y", y_out, -16384);
        check("R6 new gain x", x_out, 0);
        // R6: select 3 writes nothing
        load_state(16384, 8192);
        wr_coef(2'd3, 32'h12345678);
        pulse_step();
        model(16384, 8192, 16384, 0, 0, ex, ey);
        check("R6 sel3 x", x_out, ex);
        check("R6 sel3 y", y_out, ey);

        // R7: derived y-lane gain equals loaded negation
        set_gains(1636, 12345, -82);
        load_state(16384, 4000);
        a2_from_a1 = 1'b1;
        pulse_step();
        a2_from_a1 = 1'b0;
        mx = x_out; my = y_out;
        model(16384, 4000, 1636, -1636, -82, ex, ey);
        check("R7 derived y", my, ey);
        wr_coef(2'd1, -1636);
        load_state(16384, 4000);
        pulse_step();
        check("R7 bit match x", x_out, mx);
        check("R7 bit match y", y_out, my);
        set_gains(32'h80000000, 0, 0);
        load_state(16384, 0);
        a2_from_a1 = 1'b1;
        pulse_step();
        a2_from_a1 = 1'b0;
        check("R7 min negation y", y_out, 32'h7FFFFFFF);

        // R10: long run at h = 0.001
        k1 = to_fx(0.001 - 0.001 * 0.001 * 0.001 / 6.0);
        k2 = -k1;
        k3 = to_fx(0.001 * 0.001 * 0.001 * 0.001 / 24.0 - 0.001 * 0.001 / 2.0);
        set_gains(k1, k2, k3);
        load_state(16384, 0);
        ex = 16384; ey = 0; mism = 0;
        step = 1'b1;
        for (int s = 0; s < 6300; s++) begin
            @(negedge clk);
            model(ex, ey, k1, k2, k3, ex2, ey2);
            ex = ex2; ey = ey2;
            if (x_out != ex || y_out != ey) mism++;
        end
        step = 1'b0;
        check("R10 trajectory mismatches", mism, 0);
        ax = $itor(x_out) / 16384.0;
        ay = $itor(y_out) / 16384.0;
        amp = $sqrt(ax * ax + ay * ay);
        n_chk++;
        if (amp < 0.99 || amp > 1.01) begin
            n_bad++;
            $display("FAIL R10 amplitude actual=%f expected=1.0", amp);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule